// File: doc/BRIEF.md
# DDR2 Command Timing Checker

This block sits beside a DDR2 memory controller and observes its command stream, one command per clock. It keeps the open or closed state of each of eight banks. It also keeps two gap counters per bank. For every command it decides whether the command breaks a bank-state rule or a minimum-spacing rule. The verdict appears on a violation flag together with a reason code. A flagged command leaves every bank unchanged.

The block also supports posted column commands with additive latency. An accepted READ schedules a read data-valid window at read latency RL = AL + CL. An accepted WRITE schedules a write data-enable window one cycle earlier, at RL - 1. Each window is as long as the burst occupies the data bus. The spacing limits are fixed cycle counts. A mode input selects between a fast set and a slower set of counts. Addresses play no part in timing, so only the bank field is taken in.

Top module: `ddr2_cmd_checker`

## Requirements
- R1: After reset all banks are closed, viol_o is 0, reason_o is 0, and rd_valid_o and wr_en_o are 0.
- R2: A READ (cmd 2) or WRITE (cmd 3) to a closed bank gives viol_o=1 with reason 1 and produces no data strobe.
- R3: An ACTIVATE (cmd 1) to a bank that is already open gives reason 3, and the bank stays open.
- R4: A READ or WRITE to an open bank gives reason 2 when the cycle gap since that bank's ACTIVATE plus AL is below tRCD, and is accepted otherwise. tRCD is 5 cycles when slow_bin_i=0 and 6 cycles when slow_bin_i=1.
- R5: An ACTIVATE to a closed bank less than tRP cycles after its PRECHARGE (cmd 4) gives reason 4. tRP is 5 cycles (fast) or 6 cycles (slow).
- R6: An ACTIVATE to a closed bank that meets tRP but comes less than tRC cycles after the bank's last accepted ACTIVATE gives reason 5. tRC is 23 cycles (fast) or 24 cycles (slow). The order of precedence is reason 3, then 4, then 5.
- R7: Banks are independent. A command to one bank is judged only by that bank's history.
- R8: After an accepted READ sampled at edge t, rd_valid_o is high in the cycles after edges t+RL through t+RL+BL/2-1, where RL = al_i + cl_i. BL is 8 when bl8_i=1 and 4 when bl8_i=0.
- R9: After an accepted WRITE sampled at edge t, wr_en_o is high in the cycles after edges t+RL-1 through t+RL+BL/2-2.
- R10: A command that raises a violation changes no bank state. For example, a flagged ACTIVATE does not open its bank.
- R11: A PRECHARGE to a closed bank is legal and raises no violation.
- R12: viol_o and reason_o are registered and describe the command sampled at the previous edge. A NOP (cmd 0, or the unused codes 5 to 7) gives viol_o=0 and reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank_i | input | 3 | Bank addressed by the command |
| cl_i | input | 3 | CAS latency, 3 to 6 |
| al_i | input | 3 | Additive latency, 0 to 5 |
| bl8_i | input | 1 | Burst length 8 when set, 4 when clear |
| slow_bin_i | input | 1 | Selects the slower set of spacing counts |
| viol_o | output | 1 | The previous command broke a rule |
| reason_o | output | 3 | 0 none, 1 column to closed bank, 2 tRCD, 3 activate to open bank, 4 tRP, 5 tRC |
| rd_valid_o | output | 1 | Read data-valid window |
| wr_en_o | output | 1 | Write data-enable window |

## Verification
The assertions assume that cl_i, al_i, bl8_i and slow_bin_i stay inside their legal ranges. They also assume these inputs do not change while a burst is scheduled. Under those assumptions the strobe windows are at least two cycles long and the bank-state rules decide the reason code. The stimulus changes mode values only right after a reset, when nothing is pending. It uses only CL 3 to 6 and AL 0 to 5.

// File: rtl/ddr2_chk_pkg.sv
package ddr2_chk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_COL_CLOSED = 3'd1,
    RSN_TRCD       = 3'd2,
    RSN_ACT_OPEN   = 3'd3,
    RSN_TRP        = 3'd4,
    RSN_TRC        = 3'd5
  } reason_e;
endpackage

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  output logic             open_o,
  output logic [CNT_W-1:0] act_gap_o,
  output logic [CNT_W-1:0] pre_gap_o
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Gap counters saturate, so idle banks impose no spacing.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o    <= 1'b0;
      act_gap_o <= SAT;
      pre_gap_o <= SAT;
    end else begin
      if (act_i)      open_o <= 1'b1;
      else if (pre_i) open_o <= 1'b0;
      if (act_i)                 act_gap_o <= ONE;
      else if (act_gap_o != SAT) act_gap_o <= act_gap_o + ONE;
      if (pre_i)                 pre_gap_o <= ONE;
      else if (pre_gap_o != SAT) pre_gap_o <= pre_gap_o + ONE;
    end
  end
endmodule

// File: rtl/ddr2_strobe_pipe.sv
module ddr2_strobe_pipe #(
  parameter int DEPTH = 16,
  parameter int SH_W  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [SH_W-1:0] offset_i,
  input  logic            bl8_i,
  output logic            strobe_o
);
  logic [DEPTH-1:0] sched_q;
  logic [DEPTH-1:0] burst;

  // BL/2 clocks of data at double rate
  assign burst = bl8_i ? DEPTH'(4'b1111) : DEPTH'(4'b0011);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sched_q <= '0;
    else         sched_q <= (sched_q >> 1) | (fire_i ? (burst << offset_i) : '0);
  end

  assign strobe_o = sched_q[0];
endmodule

// File: rtl/ddr2_cmd_checker.sv
module ddr2_cmd_checker
  import ddr2_chk_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_W     = $clog2(NUM_BANKS),
  parameter int CNT_W      = 6,
  parameter int LAT_W      = 4,
  parameter int PIPE_DEPTH = 16,
  parameter int T_RCD_FAST = 5,
  parameter int T_RP_FAST  = 5,
  parameter int T_RC_FAST  = 23,
  parameter int T_RCD_SLOW = 6,
  parameter int T_RP_SLOW  = 6,
  parameter int T_RC_SLOW  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [2:0]        cl_i,
  input  logic [2:0]        al_i,
  input  logic              bl8_i,
  input  logic              slow_bin_i,
  output logic              viol_o,
  output logic [2:0]        reason_o,
  output logic              rd_valid_o,
  output logic              wr_en_o
);
  localparam int CMP_W = CNT_W + 1;

  logic [NUM_BANKS-1:0] bank_open;
  logic [NUM_BANKS-1:0] act_vec, pre_vec;
  logic [CNT_W-1:0]     act_gap [NUM_BANKS];
  logic [CNT_W-1:0]     pre_gap [NUM_BANKS];

  logic [CMP_W-1:0] t_rcd, t_rp, t_rc, cur_act, cur_pre, col_gap;
  logic             cur_open;
  reason_e          reason;
  cmd_e             cmd;
  logic             accept, act_ok, pre_ok, rd_ok, wr_ok;
  logic [LAT_W-1:0] rl, wl;

  assign cmd   = cmd_e'(cmd_i);
  assign t_rcd = slow_bin_i ? CMP_W'(T_RCD_SLOW) : CMP_W'(T_RCD_FAST);
  assign t_rp  = slow_bin_i ? CMP_W'(T_RP_SLOW)  : CMP_W'(T_RP_FAST);
  assign t_rc  = slow_bin_i ? CMP_W'(T_RC_SLOW)  : CMP_W'(T_RC_FAST);

  assign cur_open = bank_open[bank_i];
  assign cur_act  = {1'b0, act_gap[bank_i]};
  assign cur_pre  = {1'b0, pre_gap[bank_i]};
  assign col_gap  = cur_act + CMP_W'(al_i);  // posted CAS credit

  always_comb begin
    reason = RSN_NONE;
    unique case (cmd)
      CMD_ACT: begin
        if (cur_open)           reason = RSN_ACT_OPEN;
        else if (cur_pre < t_rp) reason = RSN_TRP;
        else if (cur_act < t_rc) reason = RSN_TRC;
      end
      CMD_RD, CMD_WR: begin
        if (!cur_open)            reason = RSN_COL_CLOSED;
        else if (col_gap < t_rcd) reason = RSN_TRCD;
      end
      default: reason = RSN_NONE;
    endcase
  end

  assign accept = (reason == RSN_NONE);
  assign act_ok = accept && (cmd == CMD_ACT);
  assign pre_ok = accept && (cmd == CMD_PRE) && cur_open;
  assign rd_ok  = accept && (cmd == CMD_RD);
  assign wr_ok  = accept && (cmd == CMD_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_vec[b] = act_ok && (bank_i == BANK_W'(b));
    assign pre_vec[b] = pre_ok && (bank_i == BANK_W'(b));
    ddr2_bank_timer #(.CNT_W(CNT_W)) i_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act_vec[b]),
      .pre_i     (pre_vec[b]),
      .open_o    (bank_open[b]),
      .act_gap_o (act_gap[b]),
      .pre_gap_o (pre_gap[b])
    );
  end

  assign rl = LAT_W'(al_i) + LAT_W'(cl_i);
  assign wl = rl - LAT_W'(1);

  ddr2_strobe_pipe #(.DEPTH(PIPE_DEPTH), .SH_W(LAT_W)) i_rd_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (rd_ok),
    .offset_i (rl),
    .bl8_i    (bl8_i),
    .strobe_o (rd_valid_o)
  );

  ddr2_strobe_pipe #(.DEPTH(PIPE_DEPTH), .SH_W(LAT_W)) i_wr_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (wr_ok),
    .offset_i (wl),
    .bl8_i    (bl8_i),
    .strobe_o (wr_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o   <= 1'b0;
      reason_o <= RSN_NONE;
    end else begin
      viol_o   <= !accept;
      reason_o <= reason;
    end
  end
endmodule

// File: rtl/ddr2_cmd_checker_sva.sv
module ddr2_cmd_checker_sva #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           cmd_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 viol_o,
  input logic [2:0]           reason_o,
  input logic                 rd_valid_o,
  input logic                 wr_en_o,
  input logic [NUM_BANKS-1:0] bank_open
);
  a_r2_col_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == 3'd2 || cmd_i == 3'd3) && !bank_open[bank_i]) |=> (viol_o && reason_o == 3'd1));

  a_r3_act_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && bank_open[bank_i]) |=> (viol_o && reason_o == 3'd3));

  a_r10_viol_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (bank_open == $past(bank_open)));

  a_r8_rd_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |=> rd_valid_o);

  a_r9_wr_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |=> wr_en_o);

  a_r12_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0) |=> (!viol_o && reason_o == 3'd0));
endmodule

bind ddr2_cmd_checker ddr2_cmd_checker_sva #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .bank_i     (bank_i),
  .viol_o     (viol_o),
  .reason_o   (reason_o),
  .rd_valid_o (rd_valid_o),
  .wr_en_o    (wr_en_o),
  .bank_open  (bank_open)
);

// File: tb/test_ddr2_cmd_checker.sv
module test_ddr2_cmd_checker;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic [2:0] bank = '0;
  logic [2:0] cl = 3'd3;
  logic [2:0] al = 3'd0;
  logic       bl8 = 1'b0;
  logic       slow = 1'b0;
  logic       viol;
  logic [2:0] reason;
  logic       rd_valid, wr_en;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ddr2_cmd_checker i_ddr2_cmd_checker (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .cl_i(cl), .al_i(al),
    .bl8_i(bl8), .slow_bin_i(slow), .viol_o(viol), .reason_o(reason),
    .rd_valid_o(rd_valid), .wr_en_o(wr_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd = NOP;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input int c, input int b);
    cmd = 3'(c);
    bank = 3'(b);
    @(posedge clk);
    @(negedge clk);
    cmd = NOP;
  endtask

  task automatic issue_chk(input int c, input int b, input int exp_rsn, input string tag);
    issue(c, b);
    chk({tag, " reason"}, reason, exp_rsn);
    chk({tag, " viol"}, viol, exp_rsn != 0);
  endtask

  // Called at the negedge right after the command edge (j = 0).
  task automatic check_burst(input bit is_rd, input string tag);
    int lat = is_rd ? (al + cl) : (al + cl - 1);
    int n = bl8 ? 4 : 2;
    for (int j = 0; j <= lat + n + 2; j++) begin
      chk(tag, is_rd ? rd_valid : wr_en, (j >= lat && j < lat + n) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 viol", viol, 0);
    chk("R1 reason", reason, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_en", wr_en, 0);
    issue_chk(RD, 0, 1, "R1 banks closed");
  endtask

  task automatic t_closed();
    do_reset();
    issue(WR, 3);
    chk("R2 reason", reason, 1);
    chk("R2 viol", viol, 1);
    for (int j = 1; j < 14; j++) begin
      @(negedge clk);
      chk("R2 no strobe", wr_en | rd_valid, 0);
      if (j == 1) chk("R12 nop quiet", viol, 0);
    end
  endtask

  task automatic t_trcd();
    do_reset();
    slow = 1'b0; al = 3'd0;
    issue_chk(ACT, 1, 0, "R4 act");
    idle(3);
    issue_chk(RD, 1, 2, "R4 gap4 al0");
    issue_chk(RD, 1, 0, "R4 gap5 al0");
    al = 3'd1;
    issue_chk(ACT, 2, 0, "R4 act al1");
    idle(2);
    issue_chk(WR, 2, 2, "R4 gap3 al1");
    issue_chk(WR, 2, 0, "R4 gap4 al1");
    do_reset();
    slow = 1'b1; al = 3'd0;
    issue_chk(ACT, 3, 0, "R4 act slow");
    idle(4);
    issue_chk(RD, 3, 2, "R4 gap5 slow");
    issue_chk(WR, 3, 0, "R4 gap6 slow");
    idle(16);
    slow = 1'b0;
  endtask

  task automatic t_act_open();
    do_reset();
    issue_chk(ACT, 4, 0, "R3 first act");
    issue_chk(ACT, 4, 3, "R3 act open");
    idle(4);
    issue_chk(RD, 4, 0, "R3 still open");
  endtask

  task automatic t_trp();
    do_reset();
    issue_chk(ACT, 5, 0, "R5 act");
    idle(30);
    issue_chk(PRE, 5, 0, "R5 pre");
    issue_chk(ACT, 5, 4, "R5 gap1");
    issue_chk(RD, 5, 1, "R10 flagged act kept closed");
    issue_chk(ACT, 5, 4, "R5 gap3");
    idle(1);
    issue_chk(ACT, 5, 0, "R5 gap5");
    issue_chk(PRE, 6, 0, "R11 pre closed");
    do_reset();
    slow = 1'b1;
    issue_chk(ACT, 5, 0, "R5 act slow");
    idle(30);
    issue_chk(PRE, 5, 0, "R5 pre slow");
    idle(4);
    issue_chk(ACT, 5, 4, "R5 gap5 slow");
    issue_chk(ACT, 5, 0, "R5 gap6 slow");
    slow = 1'b0;
  endtask

  task automatic t_trc();
    do_reset();
    issue_chk(ACT, 6, 0, "R6 act");
    idle(4);
    issue_chk(PRE, 6, 0, "R6 pre");
    idle(5);
    issue_chk(ACT, 6, 5, "R6 gap11");
    idle(10);
    issue_chk(ACT, 6, 5, "R6 gap22");
    issue_chk(ACT, 6, 0, "R6 gap23");
    issue_chk(ACT, 6, 3, "R6 open wins");
  endtask

  task automatic t_indep();
    do_reset();
    issue_chk(ACT, 0, 0, "R7 act b0");
    issue_chk(ACT, 1, 0, "R7 act b1");
    issue_chk(RD, 2, 1, "R7 rd b2 closed");
    issue_chk(PRE, 0, 0, "R7 pre b0");
    issue_chk(RD, 1, 2, "R7 rd b1 trcd");
    issue_chk(RD, 0, 1, "R7 rd b0 closed");
  endtask

  task automatic t_latency(input int c, input int a, input bit b8, input bit is_rd);
    do_reset();
    cl = 3'(c); al = 3'(a); bl8 = b8;
    issue(ACT, 7);
    idle(8);
    issue(is_rd ? RD : WR, 7);
    chk(is_rd ? "R8 accept" : "R9 accept", viol, 0);
    check_burst(is_rd, is_rd ? "R8 rd window" : "R9 wr window");
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_closed();
    t_trcd();
    t_act_open();
    t_trp();
    t_trc();
    t_indep();
    t_latency(3, 0, 1'b0, 1'b1);
    t_latency(6, 5, 1'b1, 1'b1);
    t_latency(4, 2, 1'b1, 1'b1);
    t_latency(3, 0, 1'b0, 1'b0);
    t_latency(5, 3, 1'b1, 1'b0);
    t_latency(6, 5, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule